// File: doc/BRIEF.md
# Parallel Flash Bus Mode Decoder

This block sits between the package pins of a parallel NOR-style flash memory model and its internals. It registers the chip enable, output enable, write enable, hardware reset and bus-width select inputs once, then decodes them into one of five bus modes: standby, read, write, output disable or hardware reset. From that mode it drives the per-bit output enables of the 16-bit data bus and selects what the bus returns on a read. In byte-wide operation the top data pin becomes the least significant address bit, and the upper bus lanes float.

Write cycles are captured while the write condition holds. When the condition ends, the block issues a one-cycle write strobe to the command logic. A write aimed at one of the two outermost boot sectors is gated by the write-protect pin. That pin can hold those sectors locked, defer to their stored protection state, or, when it is at its high-voltage level, unlock every sector and mark the write as an accelerated program. A blocked write sets a sticky violation flag instead of pulsing the strobe.

The memory array, command sequencing, program and erase timing, and analog level detection are outside this block. The high-voltage level arrives as a digital flag.

Top module: `flashPinDecoder`

## Requirements
- R1: With the reset pin low, the mode is hardware reset (code 4) whatever the other controls are, all sixteen output enables are 0 and no write strobe is issued.
- R2: With the reset pin high and chip enable high, the mode is standby (code 0), all output enables are 0 and no write strobe is issued.
- R3: Chip enable low, output enable low and write enable high give read mode (code 1). In word mode (byte select high) all sixteen output enables are 1, the bus returns the array word, and the array address is {address pins, 1'b0}.
- R4: In read mode with byte select low, only enables 7:0 are 1. The array address is {address pins, DQ15 input}. DQ7..DQ0 return the array's high byte when DQ15 is 1 and its low byte when DQ15 is 0, and bits 15:8 of the output are 0.
- R5: Chip enable low, output enable high and write enable low give write mode (code 2), with all output enables 0. In the second clock after the first sampled cycle in which the write condition is gone, the strobe is high for exactly one cycle. It carries the address and data of the last write sample: in word mode the address is {pins, 0} and the data is all 16 bits. In byte mode the address is {pins, DQ15}, the data is {8'h00, DQ7..DQ0}, and the byte flag is 1.
- R6: Chip enable low with output enable and write enable both high, or both low, gives output disable (code 3), all output enables 0 and no write strobe.
- R7: The bottom boot sector is every word address with bits 20:12 all 0, and the top boot sector is every word address with bits 20:12 all 1. With the write-protect pin low and no high-voltage flag, writes to either are blocked regardless of the stored protection state.
- R8: With the write-protect pin high and no high-voltage flag, a write to the bottom sector is blocked when stored protection bit 0 is 1, and a write to the top sector is blocked when bit 1 is 1. Writes outside the two boot sectors are never blocked.
- R9: With the high-voltage flag set during the write, no sector is blocked, and the accelerate flag is high together with the strobe.
- R10: A blocked write issues no strobe and sets the violation flag. The flag stays set through later writes and reads and clears only on the system reset.
- R11: A write condition that ends in hardware reset is abandoned and issues no strobe.
- R12: The mode and output enables follow a pin change after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| ceN | input | 1 | Chip enable pin, active low |
| oeN | input | 1 | Output enable pin, active low |
| weN | input | 1 | Write enable pin, active low |
| resetPinN | input | 1 | Hardware reset pin, active low |
| byteN | input | 1 | Bus width select: 1 word, 0 byte |
| wpPin | input | 1 | Write-protect pin logic level |
| wpHv | input | 1 | Write-protect pin at high-voltage level |
| addrPin | input | 21 | Word address pins |
| dqIn | input | 16 | Data pins as seen from outside |
| arrayRdData | input | 16 | Word read from the memory array |
| bootProt | input | 2 | Stored protection: bit 0 bottom, bit 1 top boot sector |
| dqOut | output | 16 | Data driven toward the pins |
| dqOe | output | 16 | Per-bit output enable of the data pins |
| busMode | output | 3 | Decoded mode: 0 standby, 1 read, 2 write, 3 output disable, 4 reset |
| arrayAddr | output | 22 | Byte-granular read address to the array |
| wrStrobe | output | 1 | One-cycle write strobe to the command logic |
| wrAccel | output | 1 | Accelerated program flag, valid with the strobe |
| wrByte | output | 1 | Captured write was byte-wide |
| wrAddr | output | 22 | Captured write address, A-1 as bit 0 |
| wrData | output | 16 | Captured write data |
| protViolation | output | 1 | Sticky flag: a write was blocked |

## Verification
A wrong decode of the control pins shows up one clock after the pin change, both on the mode code and on the output enables. The stimulus therefore sets each combination and reads both ports at the next falling edge. A corrupted capture latch or protection decision stays hidden until the write condition ends. It then shows two clocks later as a wrong strobe, wrong address or data, or a violation flag that should not have moved. For that reason every write is closed out and the strobe window is examined cycle by cycle. A lost sticky flag is only visible on later writes, so the flag is read again after unblocked writes and aborted cycles.

// File: rtl/flashPinPkg.sv
package flashPinPkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_READ    = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_OUTDIS  = 3'd3,
    MODE_RESET   = 3'd4
  } busMode_e;

  typedef struct packed {
    logic driveWord;   // read, word-wide bus
    logic driveByte;   // read, byte-wide bus
    logic byteMode;    // registered byte select is low
    logic captureWr;   // write condition present this cycle
    logic commitWr;    // write condition just ended normally
  } ctrlStrobes_t;

endpackage

// File: rtl/flashModeCtrl.sv
module flashModeCtrl
  import flashPinPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         weN,
  input  logic         resetPinN,
  input  logic         byteN,
  output busMode_e     modeNow,
  output ctrlStrobes_t ctl
);

  logic ceQ, oeQ, weQ, rstPinQ, byteQ;
  logic prevWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ     <= 1'b1;
      oeQ     <= 1'b1;
      weQ     <= 1'b1;
      rstPinQ <= 1'b1;
      byteQ   <= 1'b1;
    end else begin
      ceQ     <= ceN;
      oeQ     <= oeN;
      weQ     <= weN;
      rstPinQ <= resetPinN;
      byteQ   <= byteN;
    end
  end

  always_comb begin
    if (!rstPinQ)          modeNow = MODE_RESET;
    else if (ceQ)          modeNow = MODE_STANDBY;
    else if (!oeQ && weQ)  modeNow = MODE_READ;
    else if (oeQ && !weQ)  modeNow = MODE_WRITE;
    else                   modeNow = MODE_OUTDIS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevWrite <= 1'b0;
    else       prevWrite <= (modeNow == MODE_WRITE);
  end

  always_comb begin
    ctl.byteMode  = !byteQ;
    ctl.driveWord = (modeNow == MODE_READ) && byteQ;
    ctl.driveByte = (modeNow == MODE_READ) && !byteQ;
    ctl.captureWr = (modeNow == MODE_WRITE);
    ctl.commitWr  = prevWrite && (modeNow != MODE_WRITE) && (modeNow != MODE_RESET);
  end

endmodule

// File: rtl/flashBusPath.sv
module flashBusPath
  import flashPinPkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [ADDR_W-1:0] addrPin,
  input  logic [DATA_W-1:0] dqIn,
  input  logic              wpPin,
  input  logic              wpHv,
  input  logic [DATA_W-1:0] arrayRdData,
  input  logic [1:0]        bootProt,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  output logic [ADDR_W:0]   arrayAddr,
  output logic              wrStrobe,
  output logic              wrAccel,
  output logic              wrByte,
  output logic [ADDR_W:0]   wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              protViolation
);

  localparam int HALF_W = DATA_W / 2;
  localparam int TAG_W  = ADDR_W - SECT_LSB;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dqQ;
  logic              wpQ, hvQ;
  logic              aMinus;

  logic [ADDR_W:0]   wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic              wrByteQ, wrWpQ, wrHvQ;
  logic [1:0]        hitProt;
  logic              blocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dqQ   <= '0;
      wpQ   <= 1'b0;
      hvQ   <= 1'b0;
    end else begin
      addrQ <= addrPin;
      dqQ   <= dqIn;
      wpQ   <= wpPin;
      hvQ   <= wpHv;
    end
  end

  assign aMinus    = ctl.byteMode ? dqQ[DATA_W-1] : 1'b0;
  assign arrayAddr = {addrQ, aMinus};

  always_comb begin
    if (ctl.byteMode)
      dqOut = {{HALF_W{1'b0}}, (aMinus ? arrayRdData[DATA_W-1:HALF_W] : arrayRdData[HALF_W-1:0])};
    else
      dqOut = arrayRdData;
    if (ctl.driveWord)      dqOe = {DATA_W{1'b1}};
    else if (ctl.driveByte) dqOe = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    else                    dqOe = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      wrDataQ <= '0;
      wrByteQ <= 1'b0;
      wrWpQ   <= 1'b0;
      wrHvQ   <= 1'b0;
    end else if (ctl.captureWr) begin
      wrAddrQ <= {addrQ, aMinus};
      wrDataQ <= ctl.byteMode ? {{HALF_W{1'b0}}, dqQ[HALF_W-1:0]} : dqQ;
      wrByteQ <= ctl.byteMode;
      wrWpQ   <= wpQ;
      wrHvQ   <= hvQ;
    end
  end

  // sector tag of the captured word address (A-1 sits at bit 0)
  logic [TAG_W-1:0] wrTag;
  assign wrTag = wrAddrQ[ADDR_W:SECT_LSB+1];

  for (genvar g = 0; g < 2; g++) begin : gBootSect
    logic inSect;
    if (g == 0) begin : gBottom
      assign inSect = (wrTag == {TAG_W{1'b0}});
    end else begin : gTop
      assign inSect = (wrTag == {TAG_W{1'b1}});
    end
    assign hitProt[g] = inSect && !wrHvQ && (!wrWpQ || bootProt[g]);
  end

  assign blocked = |hitProt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe      <= 1'b0;
      wrAccel       <= 1'b0;
      protViolation <= 1'b0;
    end else begin
      wrStrobe      <= ctl.commitWr && !blocked;
      wrAccel       <= ctl.commitWr && !blocked && wrHvQ;
      protViolation <= protViolation || (ctl.commitWr && blocked);
    end
  end

  assign wrAddr = wrAddrQ;
  assign wrData = wrDataQ;
  assign wrByte = wrByteQ;

endmodule

// File: rtl/flashPinDecoder.sv
module flashPinDecoder
  import flashPinPkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              resetPinN,
  input  logic              byteN,
  input  logic              wpPin,
  input  logic              wpHv,
  input  logic [ADDR_W-1:0] addrPin,
  input  logic [DATA_W-1:0] dqIn,
  input  logic [DATA_W-1:0] arrayRdData,
  input  logic [1:0]        bootProt,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  output logic [2:0]        busMode,
  output logic [ADDR_W:0]   arrayAddr,
  output logic              wrStrobe,
  output logic              wrAccel,
  output logic              wrByte,
  output logic [ADDR_W:0]   wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              protViolation
);

  busMode_e     modeNow;
  ctrlStrobes_t ctl;

  flashModeCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .oeN       (oeN),
    .weN       (weN),
    .resetPinN (resetPinN),
    .byteN     (byteN),
    .modeNow   (modeNow),
    .ctl       (ctl)
  );

  flashBusPath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_LSB (SECT_LSB)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .addrPin       (addrPin),
    .dqIn          (dqIn),
    .wpPin         (wpPin),
    .wpHv          (wpHv),
    .arrayRdData   (arrayRdData),
    .bootProt      (bootProt),
    .dqOut         (dqOut),
    .dqOe          (dqOe),
    .arrayAddr     (arrayAddr),
    .wrStrobe      (wrStrobe),
    .wrAccel       (wrAccel),
    .wrByte        (wrByte),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .protViolation (protViolation)
  );

  assign busMode = modeNow;

endmodule

// File: rtl/flashPinDecoderChk.sv
module flashPinDecoderChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busMode,
  input logic [DATA_W-1:0] dqOe,
  input logic              wrStrobe,
  input logic              wrAccel,
  input logic              protViolation
);

  AST_RESET_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == 3'd4) |-> (dqOe == '0));  // R1

  AST_STANDBY_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == 3'd0) |-> (dqOe == '0));  // R2

  AST_ONLY_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (busMode != 3'd1) |-> (dqOe == '0));  // R6

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);  // R5

  AST_STROBE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ($past(busMode, 2) == 3'd2));  // R5

  AST_NO_STROBE_ON_RESET: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ($past(busMode) != 3'd4));  // R11

  AST_ACCEL_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    wrAccel |-> wrStrobe);  // R9

  AST_VIOLATION_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protViolation |=> protViolation);  // R10

endmodule

bind flashPinDecoder flashPinDecoderChk #(.DATA_W(DATA_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .busMode       (busMode),
  .dqOe          (dqOe),
  .wrStrobe      (wrStrobe),
  .wrAccel       (wrAccel),
  .protViolation (protViolation)
);

// File: tb/sim_flashPinDecoder.sv
`timescale 1ns/1ps
module sim_flashPinDecoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ceN, oeN, weN, resetPinN, byteN, wpPin, wpHv;
  logic [20:0] addrPin;
  logic [15:0] dqIn, arrayRdData;
  logic [1:0]  bootProt;
  logic [15:0] dqOut, dqOe, wrData;
  logic [2:0]  busMode;
  logic [21:0] arrayAddr, wrAddr;
  logic        wrStrobe, wrAccel, wrByte, protViolation;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flashPinDecoder u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .resetPinN(resetPinN), .byteN(byteN), .wpPin(wpPin), .wpHv(wpHv),
    .addrPin(addrPin), .dqIn(dqIn), .arrayRdData(arrayRdData),
    .bootProt(bootProt), .dqOut(dqOut), .dqOe(dqOe), .busMode(busMode),
    .arrayAddr(arrayAddr), .wrStrobe(wrStrobe), .wrAccel(wrAccel),
    .wrByte(wrByte), .wrAddr(wrAddr), .wrData(wrData),
    .protViolation(protViolation)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pins(input logic ce, input logic oe, input logic we, input logic rp);
    ceN = ce; oeN = oe; weN = we; resetPinN = rp;
  endtask

  task automatic stepNeg();
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    pins(1, 1, 1, 1);
    byteN = 1; wpPin = 1; wpHv = 0; bootProt = 2'b00;
    addrPin = '0; dqIn = '0; arrayRdData = 16'h1234;
    repeat (3) stepNeg();
    rstN = 1'b1;
    stepNeg();
    check("R2", "reset mode", busMode, 0);
    check("R2", "reset oe", dqOe, 0);
    check("R10", "reset viol", protViolation, 0);
    check("R5", "reset strobe", wrStrobe, 0);
  endtask

  task automatic testStandby();
    pins(1, 0, 1, 1);
    stepNeg(); stepNeg();
    check("R2", "standby mode", busMode, 0);
    check("R2", "standby oe", dqOe, 0);
  endtask

  task automatic testHwReset();
    pins(0, 0, 1, 0);
    stepNeg(); stepNeg();
    check("R1", "hw reset mode over read", busMode, 4);
    check("R1", "hw reset oe", dqOe, 0);
    pins(0, 1, 0, 0);
    stepNeg(); stepNeg();
    check("R1", "hw reset mode over write", busMode, 4);
    check("R1", "hw reset strobe", wrStrobe, 0);
  endtask

  task automatic testReadWord();
    pins(0, 1, 1, 1);
    stepNeg(); stepNeg();
    byteN = 1; addrPin = 21'h0ABCDE; arrayRdData = 16'hC3A5;
    pins(0, 0, 1, 1);
    #1;
    check("R12", "mode before edge", busMode, 3);
    check("R12", "oe before edge", dqOe, 0);
    stepNeg();
    check("R3", "read mode", busMode, 1);
    check("R3", "word oe", dqOe, 16'hFFFF);
    check("R3", "word data", dqOut, 16'hC3A5);
    check("R3", "word array addr", arrayAddr, {21'h0ABCDE, 1'b0});
  endtask

  task automatic testReadByte();
    byteN = 0; arrayRdData = 16'hA55A; addrPin = 21'h012345;
    dqIn = 16'h8000;
    stepNeg();
    check("R4", "byte oe", dqOe, 16'h00FF);
    check("R4", "high lane", dqOut, 16'h00A5);
    check("R4", "byte addr odd", arrayAddr, {21'h012345, 1'b1});
    dqIn = 16'h0000;
    stepNeg();
    check("R4", "low lane", dqOut, 16'h005A);
    check("R4", "byte addr even", arrayAddr, {21'h012345, 1'b0});
    byteN = 1;
  endtask

  task automatic testOutDis();
    pins(0, 1, 1, 1);
    stepNeg(); stepNeg();
    check("R6", "outdis mode", busMode, 3);
    check("R6", "outdis oe", dqOe, 0);
    pins(0, 0, 0, 1);
    stepNeg(); stepNeg(); stepNeg();
    check("R6", "both low mode", busMode, 3);
    check("R6", "both low strobe", wrStrobe, 0);
  endtask

  function automatic logic expBlocked(input logic [20:0] a, input logic wp,
                                      input logic hv, input logic [1:0] bp);
    logic bot, top;
    bot = (a[20:12] == 9'h000);
    top = (a[20:12] == 9'h1FF);
    if (hv) return 1'b0;
    if (!wp) return bot || top;
    return (bot && bp[0]) || (top && bp[1]);
  endfunction

  task automatic doWrite(input string req, input logic [20:0] a, input logic [15:0] d,
                         input logic byteMd, input logic wp, input logic hv);
    logic blk;
    logic [21:0] eAddr;
    logic [15:0] eData;
    logic prevViol;
    pins(0, 1, 1, 1);
    stepNeg(); stepNeg();
    prevViol = protViolation;
    blk = expBlocked(a, wp, hv, bootProt);
    eAddr = {a, byteMd ? d[15] : 1'b0};
    eData = byteMd ? {8'h00, d[7:0]} : d;
    byteN = !byteMd; wpPin = wp; wpHv = hv; addrPin = a; dqIn = d;
    pins(0, 1, 0, 1);
    stepNeg(); stepNeg();
    check(req, "write mode", busMode, 2);
    check(req, "write oe", dqOe, 0);
    pins(0, 1, 1, 1);
    addrPin = ~a; dqIn = ~d; wpHv = 0;
    stepNeg();
    check(req, "strobe early", wrStrobe, 0);
    stepNeg();
    check(req, "strobe", wrStrobe, !blk);
    check(req, "violation", protViolation, prevViol | blk);
    if (!blk) begin
      check(req, "wr addr", wrAddr, eAddr);
      check(req, "wr data", wrData, eData);
      check(req, "wr byte", wrByte, byteMd);
      check(req, "accel", wrAccel, hv);
    end
    stepNeg();
    check(req, "strobe single", wrStrobe, 0);
    byteN = 1;
  endtask

  task automatic testAbort();
    logic v;
    v = protViolation;
    pins(0, 1, 0, 1);
    addrPin = 21'h054321;
    stepNeg(); stepNeg();
    resetPinN = 0;
    stepNeg(); stepNeg(); stepNeg();
    check("R11", "abort strobe", wrStrobe, 0);
    check("R11", "abort mode", busMode, 4);
    check("R10", "viol kept", protViolation, v);
    pins(1, 1, 1, 1);
    stepNeg(); stepNeg();
  endtask

  task automatic testSysClear();
    rstN = 0;
    stepNeg();
    rstN = 1;
    stepNeg();
    check("R10", "viol cleared", protViolation, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testStandby();
    testHwReset();
    testReadWord();
    testReadByte();
    testOutDis();
    bootProt = 2'b11;
    doWrite("R5", 21'h0A5123, 16'hBEEF, 1'b0, 1'b0, 1'b0);
    doWrite("R5", 21'h0A5124, 16'h80C7, 1'b1, 1'b0, 1'b0);
    bootProt = 2'b00;
    doWrite("R7", 21'h000123, 16'h1111, 1'b0, 1'b0, 1'b0);
    doWrite("R7", 21'h1FF456, 16'h2222, 1'b0, 1'b0, 1'b0);
    bootProt = 2'b01;
    doWrite("R8", 21'h000777, 16'h3333, 1'b0, 1'b1, 1'b0);
    doWrite("R8", 21'h1FF777, 16'h4444, 1'b0, 1'b1, 1'b0);
    bootProt = 2'b10;
    doWrite("R8", 21'h000888, 16'h5555, 1'b0, 1'b1, 1'b0);
    doWrite("R8", 21'h1FF888, 16'h6666, 1'b0, 1'b1, 1'b0);
    bootProt = 2'b11;
    doWrite("R9", 21'h1FF999, 16'h7777, 1'b0, 1'b0, 1'b1);
    doWrite("R9", 21'h000999, 16'h8899, 1'b1, 1'b1, 1'b1);
    check("R10", "viol sticky", protViolation, 1);
    testAbort();
    testSysClear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule